// File: doc/BRIEF.md
# Strobe-Controlled Capture/Compare Timer

This block is a small timer peripheral that sits on a 32-bit register bus. Software controls it by writing one-shot strobes to start, stop, clear or snapshot the counter. A prescaler divides the base clock by a power of two before the counter advances. The counter's wrap width is chosen at run time from 8, 16, 24 or 32 bits.

Four channels each hold a compare/capture value. When the counter steps onto a channel's value, that channel raises a sticky flag. The flag can be masked onto one interrupt line. Through a shortcut mask, the same match can also zero the counter or halt it. This lets the block serve as a periodic tick source or as a one-shot delay without software stepping in.

Reads return data in the same cycle as the read strobe. Writes take effect at the next clock edge.

Top module: `evt_timer`

## Requirements
- R1: After reset, every readable register reads zero, the counter is zero and stopped, and `irq` is low.
- R2: A write with bit 0 set to 0x000 starts the counter, and one to 0x004 stops it. While running, the counter advances once per 2^P clock ticks, where P is the 4-bit field at 0x510. Stopping freezes the value without zeroing it.
- R3: A write with bit 0 set to 0x00C zeroes the counter, whether it is running or stopped. This takes priority over an advance in the same cycle.
- R4: A write with bit 0 set to 0x040+4n copies the counter value seen at that edge into channel n's register at 0x540+4n. That register is also directly writable and readable.
- R5: The 2-bit field at 0x508 picks the wrap width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The counter wraps to zero past the chosen width.
- R6: When bit 0 of 0x504 is 1 (count mode), the counter does not advance on prescaler ticks.
- R7: When the counter advances onto channel n's value, bit 0 of 0x140+4n is set one cycle later. Writing 0 there clears it. Any nonzero write leaves it unchanged.
- R8: At 0x200, only bits 11:8 and 3:0 are kept. On a channel n match, bit n zeroes the counter and bit 8+n stops it (holding the matched value). All other bits read zero.
- R9: A write to 0x304 sets, and a write to 0x308 clears, the enable bits 19:16 (other bits are ignored). Both addresses read back the current enables. `irq` is the OR over n of (flag n AND enable bit 16+n).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one cycle per access |
| re | input | 1 | Read strobe; rdata is zero when low |
| rdata | output | 32 | Read data, valid in the cycle of re |
| irq | output | 1 | Level interrupt from enabled compare flags |

## Verification
The counter has no read port, so a bad count, a bad wrap or a bad prescaler phase shows up only through a capture strobe. The wrong value appears in the channel register on the read that follows, so the bench checks each timing claim as an exact edge count between a start strobe and a capture strobe. A lost or stuck compare flag appears on `irq` and on the flag register one cycle after the match. A shortcut fault shows as a captured value that misses the expected cycle-modulo result or keeps moving after a stop match.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_START = 12'h000;
  localparam logic [ADDR_W-1:0] A_STOP  = 12'h004;
  localparam logic [ADDR_W-1:0] A_CLEAR = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CAPT0 = 12'h040;
  localparam logic [ADDR_W-1:0] A_EVT0  = 12'h140;
  localparam logic [ADDR_W-1:0] A_SHORT = 12'h200;
  localparam logic [ADDR_W-1:0] A_IESET = 12'h304;
  localparam logic [ADDR_W-1:0] A_IECLR = 12'h308;
  localparam logic [ADDR_W-1:0] A_MODE  = 12'h504;
  localparam logic [ADDR_W-1:0] A_WIDTH = 12'h508;
  localparam logic [ADDR_W-1:0] A_PRESC = 12'h510;
  localparam logic [ADDR_W-1:0] A_CC0   = 12'h540;

  localparam logic [DATA_W-1:0] SHORT_KEEP = 32'h0000_0F0F;
  localparam logic [DATA_W-1:0] IEN_KEEP   = 32'h000F_0000;

  typedef enum logic [1:0] {
    WID16 = 2'd0,
    WID8  = 2'd1,
    WID24 = 2'd2,
    WID32 = 2'd3
  } wid_sel_e;

  function automatic logic [DATA_W-1:0] wrap_mask(wid_sel_e w);
    case (w)
      WID8:    wrap_mask = 32'h0000_00FF;
      WID24:   wrap_mask = 32'h00FF_FFFF;
      WID32:   wrap_mask = 32'hFFFF_FFFF;
      default: wrap_mask = 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
  parameter int PSW = 4,
  localparam int DIVW = (1 << PSW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic [PSW-1:0] psel,
  output logic           tick
);
  logic [DIVW-1:0] div_q, div_d, lim;
  logic            div_en;

  always_comb begin
    lim    = ~({DIVW{1'b1}} << psel);
    tick   = run && ((div_q & lim) == lim);
    div_d  = (!run || restart) ? '0 : div_q + 1'b1;
    div_en = run || (div_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/evt_timer_ctr.sv
module evt_timer_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_start,
  input  logic          t_stop,
  input  logic          t_clear,
  input  logic          sc_clear,
  input  logic          sc_stop,
  input  logic          tick,
  input  logic          timer_mode,
  input  logic [CW-1:0] wmask,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic          adv_d
);
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv, zero, hold, cnt_en;

  always_comb begin
    zero   = t_clear || sc_clear;
    hold   = t_stop || sc_stop;
    adv    = tick && timer_mode && !zero && !hold;
    cnt_en = zero || adv;
    cnt_d  = zero ? '0 : ((cnt_q + 1'b1) & wmask);
    if (hold)         run_d = 1'b0;
    else if (t_start) run_d = 1'b1;
    else              run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      adv_d <= 1'b0;
    end else begin
      run_q <= run_d;
      adv_d <= adv;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run = run_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_t,
  input  logic          cc_we,
  input  logic [CW-1:0] wdata,
  input  logic          ev_wr,
  input  logic          wzero,
  input  logic [CW-1:0] cnt,
  input  logic          adv_d,
  output logic [CW-1:0] cc,
  output logic          evt,
  output logic          match
);
  logic [CW-1:0] cc_q, cc_d;
  logic          evt_q, evt_d, cc_en;

  always_comb begin
    match = adv_d && (cnt == cc_q);
    cc_en = cap_t || cc_we;
    cc_d  = cap_t ? cnt : wdata;
    if (match)              evt_d = 1'b1;
    else if (ev_wr && wzero) evt_d = 1'b0;
    else                    evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q  <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (cc_en) cc_q <= cc_d;
    end
  end

  assign cc  = cc_q;
  assign evt = evt_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PSW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CW = DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic t_start, t_stop, t_clear, wzero;
  assign t_start = we && (addr == A_START) && wdata[0];
  assign t_stop  = we && (addr == A_STOP)  && wdata[0];
  assign t_clear = we && (addr == A_CLEAR) && wdata[0];
  assign wzero   = (wdata == '0);

  // configuration registers
  logic [DATA_W-1:0] shorts_q, shorts_d, ien_q, ien_d;
  logic              mode_q, mode_d;
  wid_sel_e          wid_q, wid_d;
  logic [PSW-1:0]    presc_q, presc_d;

  always_comb begin
    shorts_d = shorts_q;
    ien_d    = ien_q;
    mode_d   = mode_q;
    wid_d    = wid_q;
    presc_d  = presc_q;
    if (we) begin
      case (addr)
        A_SHORT: shorts_d = wdata & SHORT_KEEP;
        A_IESET: ien_d    = ien_q | (wdata & IEN_KEEP);
        A_IECLR: ien_d    = ien_q & ~(wdata & IEN_KEEP);
        A_MODE:  mode_d   = wdata[0];
        A_WIDTH: wid_d    = wid_sel_e'(wdata[1:0]);
        A_PRESC: presc_d  = wdata[PSW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      shorts_q <= '0;
      ien_q    <= '0;
      mode_q   <= 1'b0;
      wid_q    <= WID16;
      presc_q  <= '0;
    end else if (we) begin
      shorts_q <= shorts_d;
      ien_q    <= ien_d;
      mode_q   <= mode_d;
      wid_q    <= wid_d;
      presc_q  <= presc_d;
    end
  end

  // counter path
  logic          tick_w, run_w, adv_w, sc_clear, sc_stop;
  logic [CW-1:0] cnt_w;

  evt_timer_presc #(.PSW(PSW)) u_presc (
    .clk(clk), .rst_n(rst_ns), .run(run_w), .restart(t_clear || t_start),
    .psel(presc_q), .tick(tick_w)
  );

  evt_timer_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_ns), .t_start(t_start), .t_stop(t_stop),
    .t_clear(t_clear), .sc_clear(sc_clear), .sc_stop(sc_stop),
    .tick(tick_w), .timer_mode(!mode_q), .wmask(wrap_mask(wid_q)),
    .run(run_w), .cnt(cnt_w), .adv_d(adv_w)
  );

  // channels
  logic [NCH-1:0] cap_t, cc_we, ev_wr, evt_w, match_w;
  logic [CW-1:0]  cc_w [NCH];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(4 * n);
    assign cap_t[n] = we && (addr == A_CAPT0 + OFS) && wdata[0];
    assign cc_we[n] = we && (addr == A_CC0 + OFS);
    assign ev_wr[n] = we && (addr == A_EVT0 + OFS);

    evt_timer_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_ns), .cap_t(cap_t[n]), .cc_we(cc_we[n]),
      .wdata(wdata), .ev_wr(ev_wr[n]), .wzero(wzero), .cnt(cnt_w),
      .adv_d(adv_w), .cc(cc_w[n]), .evt(evt_w[n]), .match(match_w[n])
    );
  end

  assign sc_clear = |(match_w & shorts_q[NCH-1:0]);
  assign sc_stop  = |(match_w & shorts_q[8 +: NCH]);
  assign irq      = |(evt_w & ien_q[16 +: NCH]);

  // read mux
  logic [DATA_W-1:0] rd_v;
  always_comb begin
    rd_v = '0;
    case (addr)
      A_SHORT: rd_v = shorts_q;
      A_IESET: rd_v = ien_q;
      A_IECLR: rd_v = ien_q;
      A_MODE:  rd_v = {{(DATA_W-1){1'b0}}, mode_q};
      A_WIDTH: rd_v = {{(DATA_W-2){1'b0}}, wid_q};
      A_PRESC: rd_v = {{(DATA_W-PSW){1'b0}}, presc_q};
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (addr == A_EVT0 + ADDR_W'(4 * n)) rd_v = {{(DATA_W-1){1'b0}}, evt_w[n]};
      if (addr == A_CC0 + ADDR_W'(4 * n))  rd_v = cc_w[n];
    end
  end
  assign rdata = re ? rd_v : '0;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run,
  input logic [DATA_W-1:0] cnt,
  input logic              evt0,
  input logic [DATA_W-1:0] cc0
);
  // R2
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_STOP && wdata[0]) |=> !run);

  // R2
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(we && addr == A_CLEAR && wdata[0])) |=> $stable(cnt));

  // R3
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CLEAR && wdata[0]) |=> (cnt == '0));

  // R4
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CAPT0 && wdata[0]) |=> (cc0 == $past(cnt)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt0 && !(we && addr == A_EVT0 && wdata == '0)) |=> evt0);
endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .we(we), .addr(addr), .wdata(wdata),
  .run(run_w), .cnt(cnt_w), .evt0(evt_w[0]), .cc0(cc_w[0])
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        we, re;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  evt_timer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .re(re), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; one rising edge commits the write
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic settle();
    wr(12'h004, 1); wr(12'h00C, 1); wr(12'h200, 0);
    wr(12'h304, 0); wr(12'h308, 32'hFFFF_FFFF);
    for (int n = 0; n < 4; n++) wr(12'h140 + 12'(4 * n), 0);
    wr(12'h510, 0); wr(12'h508, 0); wr(12'h504, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h200, v); check("R1 shortcuts", v, 0);
    rd(12'h304, v); check("R1 enables", v, 0);
    rd(12'h540, v); check("R1 cc0", v, 0);
    rd(12'h140, v); check("R1 flag0", v, 0);
    rd(12'h508, v); check("R1 width", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    settle();
    wr(12'h000, 1); idle(5); wr(12'h040, 1);   // captures 5
    wr(12'h004, 1);                             // freezes at 6
    rd(12'h540, v); check("R2 run count", v, 5);
    idle(5); wr(12'h044, 1);
    rd(12'h544, v); check("R2 frozen", v, 6);
    wr(12'h00C, 1); wr(12'h044, 1);
    rd(12'h544, v); check("R3 clear stopped", v, 0);
    wr(12'h510, 2); wr(12'h000, 1); idle(10); wr(12'h040, 1);
    rd(12'h540, v); check("R2 prescale 4", v, 2);
    rd(12'h510, v); check("R2 prescale reg", v, 2);
  endtask

  task automatic t_clear_run();
    logic [31:0] v;
    settle();
    wr(12'h000, 1); idle(3); wr(12'h00C, 1); idle(2); wr(12'h048, 1);
    rd(12'h548, v); check("R3 clear running", v, 2);
  endtask

  task automatic t_width();
    logic [31:0] v;
    settle();
    wr(12'h508, 1); wr(12'h000, 1); idle(259); wr(12'h040, 1);
    rd(12'h540, v); check("R5 8-bit wrap", v, 3);
    wr(12'h508, 2); rd(12'h508, v); check("R5 width reg", v, 2);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    settle();
    wr(12'h504, 1); wr(12'h000, 1); idle(8); wr(12'h040, 1);
    rd(12'h540, v); check("R6 count mode idle", v, 0);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    settle();
    wr(12'h540, 100); wr(12'h548, 100); wr(12'h54C, 100);
    wr(12'h544, 3); wr(12'h000, 1); idle(10); wr(12'h004, 1);
    rd(12'h144, v); check("R7 flag set", v, 1);
    check("R9 irq masked", {31'b0, irq}, 0);
    wr(12'h304, 32'h0002_0000);
    check("R9 irq enabled", {31'b0, irq}, 1);
    wr(12'h144, 5);
    rd(12'h144, v); check("R7 nonzero ignored", v, 1);
    wr(12'h144, 0);
    rd(12'h144, v); check("R7 flag cleared", v, 0);
    check("R9 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_short_clear();
    logic [31:0] v;
    settle();
    wr(12'h540, 4); wr(12'h200, 32'h1);
    wr(12'h000, 1); idle(7); wr(12'h048, 1);
    rd(12'h548, v); check("R8 clear shortcut period", v, 2);
    rd(12'h140, v); check("R7 flag ch0", v, 1);
  endtask

  task automatic t_short_stop();
    logic [31:0] v;
    settle();
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, v); check("R8 shortcut keep", v, 32'h0000_0F0F);
    wr(12'h540, 100); wr(12'h548, 100); wr(12'h54C, 100);
    wr(12'h200, 32'h200); wr(12'h544, 6);
    wr(12'h000, 1); idle(20); wr(12'h04C, 1);
    rd(12'h54C, v); check("R8 stop shortcut", v, 6);
    idle(5); wr(12'h04C, 1);
    rd(12'h54C, v); check("R8 stays stopped", v, 6);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    settle();
    wr(12'h304, 32'hFFFF_FFFF);
    rd(12'h304, v); check("R9 enable keep", v, 32'h000F_0000);
    wr(12'h308, 32'h0002_0000);
    rd(12'h308, v); check("R9 enable clear", v, 32'h000D_0000);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_prescale();
    t_clear_run();
    t_width();
    t_mode();
    t_compare();
    t_short_clear();
    t_short_stop();
    t_enables();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule